// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 64-bit load/store datapath and a data memory port that is byte addressed and eight bytes wide. On a store it takes an access size, a byte address and the register value. It works out which byte lanes of the memory word the access covers and drives the matching write enables. It also moves the value's bytes onto those lanes. On a load it takes the word the memory returned, picks out the bytes of the object, puts them back in significance order and widens the result to 64 bits with zeros or with copies of the sign bit.

The byte order is chosen per access by a mode input, so one instance serves both little-endian and big-endian code. Every access is checked against its natural alignment. A misaligned access raises a flag and drives nothing into memory or into the register file. An optional output register, on by default, adds one cycle of latency, and a valid bit runs alongside the data.

Top module: `lsu_lane_align`

## Requirements
- R1: Byte lane i of the memory word is data bits [8i+7:8i] and holds the byte at word address plus i. An aligned store of s bytes at in-word offset o (the low three address bits) sets `byte_en` bits o to o+s-1 and clears all other bits. The size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes.
- R2: With `big_end` low, an aligned store writes byte k of the value (k=0 least significant) to lane o+k.
- R3: With `big_end` high, an aligned store writes byte k of the value to lane o+s-1-k.
- R4: An access is misaligned whenever the address modulo s is not zero. Such an access raises `misalign`, and `byte_en`, `mem_wdata` and `ld_data` are then all zero.
- R5: With `big_end` low, an aligned load returns lane o+k as byte k of the result.
- R6: With `big_end` high, an aligned load returns lane o+s-1-k as byte k of the result.
- R7: With `sext` low, a load of 1, 2 or 4 bytes clears every result bit above bit 8s-1.
- R8: With `sext` high, a load of 1, 2 or 4 bytes copies result bit 8s-1 into every higher bit. An 8-byte load is the same whichever way `sext` is set.
- R9: A load drives `byte_en` and `mem_wdata` to zero, and a store drives `ld_data` to zero. Lanes outside the access in `mem_wdata` are zero.
- R10: With the output register in place, the results for a request sampled with `in_valid` high appear one cycle later with `out_valid` high. A cycle after `in_valid` was low shows `out_valid` low and every other output at zero.
- R11: While `rst` is high at a clock edge, every output is zero the cycle after.
- R12: `mem_addr` carries the request address with its three in-word offset bits dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| is_store | input | 1 | 1 = store, 0 = load |
| size | input | 2 | Access size code (0:1, 1:2, 2:4, 3:8 bytes) |
| sext | input | 1 | Load widening: 1 = sign, 0 = zero |
| big_end | input | 1 | Byte order: 1 = big-endian, 0 = little-endian |
| addr | input | ADDR_W | Byte address |
| st_data | input | DATA_W | Store value, right-justified |
| mem_rdata | input | DATA_W | Word returned by memory |
| out_valid | output | 1 | Results valid |
| mem_addr | output | ADDR_W-3 | Memory word address |
| byte_en | output | DATA_W/8 | Per-lane write enables |
| mem_wdata | output | DATA_W | Lane-placed store data |
| ld_data | output | DATA_W | Aligned, widened load result |
| misalign | output | 1 | Access not naturally aligned |

## Verification
A wrong lane mapping shows up on the very next valid output. For a store the bytes sit on the wrong lanes of `mem_wdata`, or `byte_en` covers the wrong span. For a load the bytes of `ld_data` come out in a permuted order. A faulty alignment test either leaves enables set that should be zero or blanks an access that is legal. A faulty sign test corrupts only the bits above the object. For these reasons the sweep covers every size, offset, byte order, widening mode and direction, and uses data whose top bit is sometimes set and sometimes clear. There is no state apart from the output register, so any fault is visible in the cycle after the request that triggers it.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_DBL  = 2'd3
  } acc_size_e;

  // number of bytes an access of the given size covers
  function automatic int acc_bytes(acc_size_e s);
    return 1 << int'(s);
  endfunction
endpackage

// File: rtl/lsu_lane_mask.sv
module lsu_lane_mask
  import lsu_align_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] offset,
  input  acc_size_e        size,
  output logic             misalign,
  output logic [LANES-1:0] lane_mask
);
  int o, n;

  always_comb begin
    o = int'(offset);
    n = acc_bytes(size);
    misalign = (o % n) != 0;
    for (int i = 0; i < LANES; i++) begin
      lane_mask[i] = !misalign && (i >= o) && (i < o + n);
    end
  end
endmodule

// File: rtl/lsu_store_place.sv
module lsu_store_place
  import lsu_align_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW = LANES * 8
) (
  input  logic [DW-1:0]    st_data,
  input  logic [OFF_W-1:0] offset,
  input  acc_size_e        size,
  input  logic             big_end,
  input  logic [LANES-1:0] lane_mask,
  output logic [DW-1:0]    wdata
);
  int o, n, k;

  always_comb begin
    o = int'(offset);
    n = acc_bytes(size);
    k = 0;
    wdata = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_mask[i]) begin
        // object byte index that lands on lane i
        k = big_end ? (o + n - 1 - i) : (i - o);
        wdata[8*i +: 8] = st_data[8*k +: 8];
      end
    end
  end
endmodule

// File: rtl/lsu_load_gather.sv
module lsu_load_gather
  import lsu_align_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int DW = LANES * 8
) (
  input  logic [DW-1:0]    rdata,
  input  logic [OFF_W-1:0] offset,
  input  acc_size_e        size,
  input  logic             big_end,
  input  logic             sext,
  input  logic             misalign,
  output logic [DW-1:0]    ld
);
  int o, n, lane;
  logic sign;

  always_comb begin
    o = int'(offset);
    n = acc_bytes(size);
    lane = 0;
    ld = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < n) begin
        lane = (big_end ? (o + n - 1 - k) : (o + k)) % LANES;
        ld[8*k +: 8] = rdata[8*lane +: 8];
      end
    end
    sign = sext && ld[8*n-1];
    for (int k = 0; k < LANES; k++) begin
      if (k >= n) ld[8*k +: 8] = {8{sign}};
    end
    if (misalign) ld = '0;
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    is_store,
  input  logic [1:0]              size,
  input  logic                    sext,
  input  logic                    big_end,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       st_data,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    out_valid,
  output logic [ADDR_W-OFF_W-1:0] mem_addr,
  output logic [LANES-1:0]        byte_en,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic [DATA_W-1:0]       ld_data,
  output logic                    misalign
);
  acc_size_e         sz_e;
  logic [OFF_W-1:0]  offset;
  logic              mis_c;
  logic [LANES-1:0]  mask_c;
  logic [DATA_W-1:0] wd_c, ld_c;
  logic [LANES-1:0]  en_n;
  logic [DATA_W-1:0] wd_n, ld_n;

  assign sz_e   = acc_size_e'(size);
  assign offset = addr[OFF_W-1:0];

  lsu_lane_mask #(.LANES(LANES)) u_mask (
    .offset(offset), .size(sz_e), .misalign(mis_c), .lane_mask(mask_c)
  );

  lsu_store_place #(.LANES(LANES)) u_place (
    .st_data(st_data), .offset(offset), .size(sz_e), .big_end(big_end),
    .lane_mask(mask_c), .wdata(wd_c)
  );

  lsu_load_gather #(.LANES(LANES)) u_gather (
    .rdata(mem_rdata), .offset(offset), .size(sz_e), .big_end(big_end),
    .sext(sext), .misalign(mis_c), .ld(ld_c)
  );

  // direction gating
  assign en_n = is_store ? mask_c : '0;
  assign wd_n = is_store ? wd_c : '0;
  assign ld_n = is_store ? '0 : ld_c;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          mem_addr  <= '0;
          byte_en   <= '0;
          mem_wdata <= '0;
          ld_data   <= '0;
          misalign  <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            mem_addr  <= addr[ADDR_W-1:OFF_W];
            byte_en   <= en_n;
            mem_wdata <= wd_n;
            ld_data   <= ld_n;
            misalign  <= mis_c;
          end else begin
            mem_addr  <= '0;
            byte_en   <= '0;
            mem_wdata <= '0;
            ld_data   <= '0;
            misalign  <= 1'b0;
          end
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst;
      always_comb begin
        out_valid = in_valid;
        mem_addr  = in_valid ? addr[ADDR_W-1:OFF_W] : '0;
        byte_en   = in_valid ? en_n : '0;
        mem_wdata = in_valid ? wd_n : '0;
        ld_data   = in_valid ? ld_n : '0;
        misalign  = in_valid && mis_c;
      end
    end
  endgenerate
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int DATA_W = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              is_store,
  input logic [1:0]        size,
  input logic              sext,
  input logic              out_valid,
  input logic [LANES-1:0]  byte_en,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] ld_data,
  input logic              misalign
);
  logic seen;
  always_ff @(posedge clk) seen <= !rst;

  generate
    if (REG_OUT) begin : g_props
      p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst || !seen)
        !out_valid |-> (byte_en == '0 && !misalign && mem_wdata == '0 && ld_data == '0));

      p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst || !seen)
        out_valid == $past(in_valid));

      p_misalign_mutes_r4: assert property (@(posedge clk) disable iff (rst || !seen)
        misalign |-> (byte_en == '0 && mem_wdata == '0 && ld_data == '0));

      p_en_width_r1: assert property (@(posedge clk) disable iff (rst || !seen)
        (out_valid && !misalign && $past(is_store)) |->
          ($countones(byte_en) == (32'd1 << $past(size))));

      p_load_no_en_r9: assert property (@(posedge clk) disable iff (rst || !seen)
        (out_valid && !$past(is_store)) |-> (byte_en == '0 && mem_wdata == '0));

      p_sext_byte_r8: assert property (@(posedge clk) disable iff (rst || !seen)
        (out_valid && !misalign && !$past(is_store) && $past(sext) && $past(size) == 2'd0)
          |-> (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}}));

      p_zext_top_r7: assert property (@(posedge clk) disable iff (rst || !seen)
        (out_valid && !$past(is_store) && !$past(sext) && $past(size) != 2'd3)
          |-> ((ld_data >> (32'd8 << $past(size))) == '0));
    end
  endgenerate
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .is_store(is_store), .size(size),
  .sext(sext), .out_valid(out_valid), .byte_en(byte_en), .mem_wdata(mem_wdata),
  .ld_data(ld_data), .misalign(misalign)
);

// File: tb/sim_lsu_lane_align.sv
module sim_lsu_lane_align;
  localparam int DW = 64;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, is_store = 1'b0, sext = 1'b0, big_end = 1'b0;
  logic [1:0] size = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] st_data = '0, mem_rdata = '0;
  logic out_valid, misalign;
  logic [AW-4:0] mem_addr;
  logic [7:0] byte_en;
  logic [DW-1:0] mem_wdata, ld_data;

  int tests = 0, fails = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #5 clk = ~clk;

  lsu_lane_align #(.DATA_W(DW), .ADDR_W(AW), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .is_store(is_store), .size(size),
    .sext(sext), .big_end(big_end), .addr(addr), .st_data(st_data),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .mem_addr(mem_addr),
    .byte_en(byte_en), .mem_wdata(mem_wdata), .ld_data(ld_data),
    .misalign(misalign)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [63:0] next_rand(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic run_case(input int sz, input int off, input bit be,
                          input bit sx, input bit st, input int hi);
    logic [7:0] lanes [8];
    logic [7:0] exp_en;
    logic [63:0] exp_wd, exp_ld, sd, rd;
    int n, a;
    bit mis;
    string ttag;
    n = 1 << sz;
    mis = (off % n) != 0;
    seed = next_rand(seed); sd = seed;
    seed = next_rand(seed); rd = seed;
    exp_en = '0; exp_wd = '0; exp_ld = '0;
    // byte-array model of one memory word
    for (int i = 0; i < 8; i++) lanes[i] = 8'h00;
    if (st) begin
      for (int k = 0; k < n; k++) begin
        a = be ? (off + n - 1 - k) : (off + k);
        if (a < 8) begin
          lanes[a] = sd[8*k +: 8];
          exp_en[a] = 1'b1;
        end
      end
      for (int i = 0; i < 8; i++) exp_wd[8*i +: 8] = lanes[i];
    end else begin
      for (int i = 0; i < 8; i++) lanes[i] = rd[8*i +: 8];
      for (int k = 0; k < n; k++) begin
        a = be ? (off + n - 1 - k) : (off + k);
        if (a < 8) exp_ld[8*k +: 8] = lanes[a];
      end
      if (sx && n < 8 && exp_ld[8*n-1]) exp_ld = exp_ld | ~((64'd1 << (8*n)) - 64'd1);
    end
    if (mis) begin exp_en = '0; exp_wd = '0; exp_ld = '0; end

    @(negedge clk);
    in_valid = 1'b1; is_store = st; size = 2'(sz); sext = sx; big_end = be;
    addr = AW'(hi * 8 + off); st_data = sd; mem_rdata = rd;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "out_valid", 64'(out_valid), 64'd1);
    check("R12", "mem_addr", 64'(mem_addr), 64'(hi));
    check("R4", "misalign", 64'(misalign), 64'(mis));
    if (st) begin
      check("R1", "byte_en", 64'(byte_en), 64'(exp_en));
      ttag = mis ? "R4" : (be ? "R3" : "R2");
      check(ttag, "mem_wdata", mem_wdata, exp_wd);
      check("R9", "ld_data on store", ld_data, 64'd0);
    end else begin
      check("R9", "byte_en on load", 64'(byte_en), 64'd0);
      check("R9", "mem_wdata on load", mem_wdata, 64'd0);
      if (mis) ttag = "R4";
      else if (n < 8) ttag = sx ? "R8" : "R7";
      else ttag = be ? "R6" : "R5";
      check(ttag, "ld_data", ld_data, exp_ld);
      if (!mis) check(be ? "R6" : "R5", "ld_data low bytes",
                      ld_data & ((n == 8) ? ~64'd0 : ((64'd1 << (8*n)) - 64'd1)),
                      exp_ld & ((n == 8) ? ~64'd0 : ((64'd1 << (8*n)) - 64'd1)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs cleared while reset is applied
    check("R11", "out_valid", 64'(out_valid), 64'd0);
    check("R11", "byte_en", 64'(byte_en), 64'd0);
    check("R11", "ld_data", ld_data, 64'd0);
    check("R11", "mem_wdata", mem_wdata, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    for (int st = 0; st < 2; st++)
      for (int be = 0; be < 2; be++)
        for (int sx = 0; sx < 2; sx++)
          for (int sz = 0; sz < 4; sz++)
            for (int off = 0; off < 8; off++)
              run_case(sz, off, be[0], sx[0], st[0], 3 + off * 97 + sz);
    // R10: idle cycle after a request returns all outputs to zero
    @(negedge clk);
    check("R10", "idle out_valid", 64'(out_valid), 64'd0);
    check("R10", "idle byte_en", 64'(byte_en), 64'd0);
    check("R10", "idle ld_data", ld_data, 64'd0);
    check("R10", "idle misalign", 64'(misalign), 64'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule